// File: doc/BRIEF.md
# Selectable Clock Divider with Blanking-Synchronised Switch

This block turns a fast reference clock into a clock-enable pulse stream whose average rate is the reference rate divided by one of four fixed ratios. The stage after it, which squashes selected pulses, is a separate block. That stage is followed by a fixed halving stage. The final clock is therefore the reference rate, divided by the ratio chosen here, multiplied by the share of ones in the squash pattern, and halved.

Software asks for a new ratio by placing a select code on `reqSel` and pulsing `reqValid`. The request is held as pending. It is applied only after a start-of-vertical-blank pulse has arrived on `vblankStart`, which comes from the one display pipe that may keep running. The switch then happens at the end of the current output period, so the pipe never sees a truncated or merged pulse gap. The block shows that a request is waiting on `pending`. It raises `done` for one cycle when the new ratio takes effect.

Top module: `blank_sync_div`

## Requirements
- R1: After reset the active select `curSel` is 0 (divide by 1), `pending` and `done` are low, and `clkEn` is high in every cycle.
- R2: Select codes map to ratios as follows: 0 gives divide by 1 with `clkEn` high every cycle. 2 gives divide by 2 with the pattern 1,0. 3 gives divide by 4 with the pattern 1,0,0,0. 1 gives divide by 1.5 with the repeating pattern 1,1,0. Each pattern starts at its first entry in the cycle in which `done` is high.
- R3: A cycle with `reqValid` high stores `reqSel` and makes `pending` high from the next cycle on. Without a later blanking pulse, `curSel` stays unchanged.
- R4: A stored request is applied only after a `vblankStart` pulse that arrives in a cycle after the request. A blanking pulse in the same cycle as the request, or before it, does not count.
- R5: The switch happens at the last cycle of the output period in progress, once the blanking pulse has been registered. With the request in a period-start cycle and the blanking pulse in the next cycle, the new ratio starts L*ceil(3/L) cycles after the request cycle, where L is the old period length in cycles (1, 3, 2, 4 for codes 0, 1, 2, 3).
- R6: A new request while one is pending replaces the stored select, and it also discards a blanking pulse already seen for the older request. Only the latest select is applied.
- R7: `done` is high for exactly one cycle. That cycle is the first cycle with the new `curSel`, and in it `pending` is already low. `curSel` changes in no other cycle.
- R8: A `vblankStart` pulse while nothing is pending has no effect on `curSel`, `pending` or `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | One-cycle strobe that requests a new ratio |
| reqSel | input | 2 | Requested select code, sampled with `reqValid` |
| vblankStart | input | 1 | Start-of-vertical-blank pulse from the active pipe |
| clkEn | output | 1 | Divided clock-enable pulse stream |
| curSel | output | 2 | Select code now in effect |
| pending | output | 1 | A request is stored and not yet applied |
| done | output | 1 | One-cycle pulse in the first cycle of the new ratio |

## Verification
The bench builds the block with its default package values: a 2-bit select and a longest period of four cycles. With these values all four ratios and their enable patterns can be reached. The switch delay can be measured from each of the four old period lengths, which exercises every period-end position that the boundary rule can land on. The same build also covers a blanking pulse arriving together with a request, a second request cancelling a blanking pulse already seen, and a blanking pulse with nothing pending.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

  localparam int SEL_W   = 2;
  localparam int MAX_LEN = 4;
  localparam int PHASE_W = $clog2(MAX_LEN);

  typedef logic [SEL_W-1:0]   sel_t;
  typedef logic [PHASE_W-1:0] phase_t;

  typedef enum sel_t {
    DIV_1   = 2'd0,
    DIV_1P5 = 2'd1,
    DIV_2   = 2'd2,
    DIV_4   = 2'd3
  } div_e;

  // strobes from control to datapath
  typedef struct packed {
    logic apply;
    sel_t sel;
  } ctrl_strobe_t;

  // last phase index of one output period for a select code
  function automatic phase_t lastPhase(input sel_t s);
    case (div_e'(s))
      DIV_1:   lastPhase = phase_t'(0);
      DIV_1P5: lastPhase = phase_t'(2);
      DIV_2:   lastPhase = phase_t'(1);
      default: lastPhase = phase_t'(MAX_LEN - 1);
    endcase
  endfunction

  // enable pattern inside one output period
  function automatic logic pulseAt(input sel_t s, input phase_t p);
    case (div_e'(s))
      DIV_1:   pulseAt = 1'b1;
      DIV_1P5: pulseAt = (p != phase_t'(2));
      default: pulseAt = (p == phase_t'(0));
    endcase
  endfunction

endpackage

// File: rtl/bsd_ctrl.sv
module bsd_ctrl
  import bsd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  sel_t         reqSel,
  input  logic         vblankStart,
  input  logic         periodEnd,
  output ctrl_strobe_t strobe,
  output logic         pending
);

  sel_t pendSel;
  logic armed;
  logic applyNow;

  // a fresh request in the same cycle wins over an apply
  assign applyNow = armed && periodEnd && !reqValid;
  assign strobe   = '{apply: applyNow, sel: pendSel};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= 1'b0;
      pendSel <= sel_t'(DIV_1);
      armed   <= 1'b0;
    end else if (reqValid) begin
      pending <= 1'b1;
      pendSel <= reqSel;
      armed   <= 1'b0;
    end else if (applyNow) begin
      pending <= 1'b0;
      armed   <= 1'b0;
    end else if (vblankStart && pending) begin
      armed   <= 1'b1;
    end
  end

endmodule

// File: rtl/bsd_datapath.sv
module bsd_datapath
  import bsd_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strobe,
  output logic         clkEn,
  output sel_t         curSel,
  output logic         done,
  output logic         periodEnd
);

  phase_t phase;

  assign periodEnd = (phase == lastPhase(curSel));
  assign clkEn     = pulseAt(curSel, phase);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSel <= sel_t'(DIV_1);
      phase  <= '0;
      done   <= 1'b0;
    end else if (strobe.apply) begin
      curSel <= strobe.sel;
      phase  <= '0;
      done   <= 1'b1;
    end else begin
      done   <= 1'b0;
      phase  <= periodEnd ? '0 : phase_t'(phase + 1'b1);
    end
  end

endmodule

// File: rtl/blank_sync_div.sv
module blank_sync_div
  import bsd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] reqSel,
  input  logic       vblankStart,
  output logic       clkEn,
  output logic [1:0] curSel,
  output logic       pending,
  output logic       done
);

  ctrl_strobe_t strobe;
  logic         periodEnd;

  bsd_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqSel      (reqSel),
    .vblankStart (vblankStart),
    .periodEnd   (periodEnd),
    .strobe      (strobe),
    .pending     (pending)
  );

  bsd_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .clkEn     (clkEn),
    .curSel    (curSel),
    .done      (done),
    .periodEnd (periodEnd)
  );

endmodule

// File: rtl/blank_sync_div_chk.sv
module blank_sync_div_chk (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic       vblankStart,
  input logic       clkEn,
  input logic [1:0] curSel,
  input logic       pending,
  input logic       done
);

  p_div1_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    (curSel == 2'd0) |-> clkEn);

  p_single_pulse_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((curSel == 2'd2 || curSel == 2'd3) && clkEn) |=> !clkEn);

  p_req_pending_r3: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> pending);

  p_boundary_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> clkEn);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_sel_change_done_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curSel) |-> done);

  p_done_clears_pending_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !pending);

  p_idle_vblank_r8: assert property (@(posedge clk) disable iff (!rstN)
    (vblankStart && !pending && !reqValid) |=> (!done && !pending));

endmodule

bind blank_sync_div blank_sync_div_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .vblankStart (vblankStart),
  .clkEn       (clkEn),
  .curSel      (curSel),
  .pending     (pending),
  .done        (done)
);

// File: tb/blank_sync_div_bench.sv
module blank_sync_div_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [1:0] reqSel = 2'd0;
  logic       vblankStart = 1'b0;
  logic       clkEn;
  logic [1:0] curSel;
  logic       pending;
  logic       done;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  logic [1:0] expQ[$];
  logic [1:0] monExp;

  always #10 clk = ~clk;  // 50 MHz

  blank_sync_div u_blank_sync_div (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqSel      (reqSel),
    .vblankStart (vblankStart),
    .clkEn       (clkEn),
    .curSel      (curSel),
    .pending     (pending),
    .done        (done)
  );

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  function automatic int periodLen(input logic [1:0] s);
    case (s)
      2'd0: periodLen = 1;
      2'd1: periodLen = 3;
      2'd2: periodLen = 2;
      default: periodLen = 4;
    endcase
  endfunction

  function automatic int expEn(input logic [1:0] s, input int k);
    case (s)
      2'd0: expEn = 1;
      2'd1: expEn = (k % 3 != 2) ? 1 : 0;
      2'd2: expEn = (k % 2 == 0) ? 1 : 0;
      default: expEn = (k % 4 == 0) ? 1 : 0;
    endcase
  endfunction

  // scoreboard monitor: every done pops one expected select
  always @(negedge clk) begin
    if (rstN && done && !finished) begin
      nChecks++;
      if (expQ.size() == 0) begin
        nFails++;
        $display("FAIL R7 unexpected done actual=1 expected=0");
      end else begin
        monExp = expQ.pop_front();
        if (curSel != monExp) begin
          nFails++;
          $display("FAIL R6 applied select actual=%0d expected=%0d", curSel, monExp);
        end
      end
    end
  end

  // called on the done cycle; runs 12 cycles, ending at a period start
  task automatic checkPattern(input logic [1:0] s);
    for (int k = 0; k < 12; k++) begin
      chk("R2 enable pattern", int'(clkEn), expEn(s, k));
      if (k == 1) chk("R7 done lasts one cycle", int'(done), 0);
      cyc();
    end
  endtask

  // called at a period start of oldSel
  task automatic switchTo(input logic [1:0] newSel, input logic [1:0] oldSel);
    int len;
    int dly;
    len = periodLen(oldSel);
    dly = len * ((3 + len - 1) / len);
    reqSel = newSel;
    reqValid = 1'b1;
    cyc();
    reqValid = 1'b0;
    chk("R3 pending after request", int'(pending), 1);
    chk("R3 select held", int'(curSel), int'(oldSel));
    expQ.push_back(newSel);
    vblankStart = 1'b1;
    cyc();
    vblankStart = 1'b0;
    for (int i = 2; i <= dly; i++) begin
      if (i < dly) begin
        chk("R5 no early switch", int'(done), 0);
        chk("R5 old select kept", int'(curSel), int'(oldSel));
        cyc();
      end else begin
        chk("R5 switch at period end", int'(done), 1);
        chk("R5 new select", int'(curSel), int'(newSel));
        chk("R7 pending low at done", int'(pending), 0);
      end
    end
  endtask

  initial begin
    #(20ns * 200000);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) cyc();
    rstN = 1'b1;
    cyc();
    chk("R1 reset select", int'(curSel), 0);
    chk("R1 reset pending", int'(pending), 0);
    chk("R1 reset done", int'(done), 0);
    for (int k = 0; k < 4; k++) begin
      chk("R1 enable every cycle", int'(clkEn), 1);
      cyc();
    end

    // blanking pulse with nothing stored
    vblankStart = 1'b1;
    cyc();
    vblankStart = 1'b0;
    for (int k = 0; k < 6; k++) begin
      chk("R8 no done", int'(done), 0);
      chk("R8 no pending", int'(pending), 0);
      chk("R8 select kept", int'(curSel), 0);
      cyc();
    end

    // walk through every ratio and every old period length
    switchTo(2'd1, 2'd0); checkPattern(2'd1);
    switchTo(2'd2, 2'd1); checkPattern(2'd2);
    switchTo(2'd3, 2'd2); checkPattern(2'd3);
    switchTo(2'd0, 2'd3); checkPattern(2'd0);

    // R6: newer request overrides and discards the seen blanking pulse
    reqSel = 2'd2;
    reqValid = 1'b1;
    cyc();
    reqValid = 1'b0;
    vblankStart = 1'b1;
    cyc();
    vblankStart = 1'b0;
    reqSel = 2'd3;
    reqValid = 1'b1;
    cyc();
    reqValid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      chk("R6 no apply after override", int'(done), 0);
      chk("R6 still pending", int'(pending), 1);
      chk("R6 select kept", int'(curSel), 0);
      cyc();
    end
    expQ.push_back(2'd3);
    vblankStart = 1'b1;
    cyc();
    vblankStart = 1'b0;
    cyc();
    chk("R6 latest select applied", int'(curSel), 3);
    chk("R6 done raised", int'(done), 1);
    checkPattern(2'd3);

    // R4: blanking pulse in the request cycle does not count
    reqSel = 2'd1;
    reqValid = 1'b1;
    vblankStart = 1'b1;
    cyc();
    reqValid = 1'b0;
    vblankStart = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk("R4 no apply without later blanking", int'(done), 0);
      chk("R4 pending kept", int'(pending), 1);
      chk("R4 select kept", int'(curSel), 3);
      cyc();
    end
    expQ.push_back(2'd1);
    vblankStart = 1'b1;
    cyc();
    vblankStart = 1'b0;
    for (int i = 0; i < 10 && !done; i++) cyc();
    chk("R4 applied after later blanking", int'(done), 1);
    chk("R4 new select", int'(curSel), 1);
    checkPattern(2'd1);

    // R8 again at a non-default ratio
    vblankStart = 1'b1;
    cyc();
    vblankStart = 1'b0;
    for (int k = 0; k < 6; k++) begin
      chk("R8 idle blanking ignored", int'(done), 0);
      chk("R8 select kept", int'(curSel), 1);
      cyc();
    end

    chk("R7 every expected done seen", expQ.size(), 0);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule